// File: doc/BRIEF.md
# Linked-Descriptor Outbound DMA Channel

This block is one transmit channel of a DMA engine. It follows a chain of descriptors held in memory and delivers the bytes of each described buffer, in address order, to a client over a valid/ready byte stream. A descriptor is four consecutive 32-bit words at a word-aligned address. Word 0 holds the buffer start and word 1 the address one past the last byte. Word 2 holds the address of the next descriptor. Word 3 holds the flags: bit 0 ends the chain and bit 1 requests an interrupt when the buffer is finished.

A register block drives two one-cycle commands. A context load points the channel at a descriptor and fetches it, but the channel stays stopped. A start clears the end-of-list state and runs the chain from the saved context. Progress is held in two visible pointers: the current descriptor and the current buffer position. The count still to send is always the descriptor's end address minus the buffer position. After each buffer, the channel writes the descriptor's flags word back to memory. It then either stops at an end-of-list descriptor or moves on to the next descriptor in the chain.

Top module: `dchain_out_chan`

## Requirements
- R1: A synchronous active-high reset leaves the channel idle, with `end_of_list` at 1, both pointers at 0, and `rd_req`, `wr_req`, `out_valid` and `buf_irq` all at 0.
- R2: `cmd_load` while idle sets the descriptor pointer to `load_desc_addr`. The channel then reads the four descriptor words from that address plus 0, 4, 8 and 12, and sets the buffer pointer to word 0. It emits no stream bytes and leaves `end_of_list` unchanged.
- R3: `cmd_start` while idle clears `end_of_list` one cycle later. The channel re-reads the current descriptor and streams bytes from the saved buffer pointer. The byte at address A is lane A[1:0] of the little-endian word at A with its two low bits cleared, and lane 0 is bits 7:0.
- R4: `out_valid` and `out_data` stay unchanged while `out_ready` is low. The buffer pointer rises by exactly one for each byte the client accepts.
- R5: A buffer holds end minus buffer-pointer bytes. An end address equal to the pointer sends no bytes, and so does an end address below it.
- R6: When a buffer finishes and its flags word has bit 1 set, `buf_irq` pulses for exactly one cycle.
- R7: After the last byte of each buffer, the channel writes one word to descriptor address plus 12, before it fetches any further descriptor. The word carries the read bit 0 and bit 1, with bit 2 set to 1 and all other bits 0.
- R8: After writing back a descriptor whose bit 0 is set, the channel sets `end_of_list` and goes idle. It issues no reads, writes or stream bytes until the next start.
- R9: After writing back a descriptor whose bit 0 is clear, the descriptor pointer becomes word 2. The channel fetches that descriptor and sets the buffer pointer to its word 0.
- R10: `cmd_load` and `cmd_start` are ignored while the channel is fetching, streaming or writing back. If both arrive together while idle, the start wins.
- R11: `rd_req` and `wr_req` are never high together. Each request holds its address, and its write data, unchanged until `rd_valid` or `wr_ack` answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle start command |
| cmd_load | input | 1 | One-cycle context-load command |
| load_desc_addr | input | ADDR_W | Descriptor address for a context load |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Word-aligned read address |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 32 | Read data word |
| wr_req | output | 1 | Descriptor write-back request |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | 32 | Write-back word |
| wr_ack | input | 1 | Write accepted this cycle |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_ready | input | 1 | Client accepts the byte |
| buf_irq | output | 1 | One-cycle buffer-complete interrupt pulse |
| end_of_list | output | 1 | Channel has stopped at the end of the chain |
| cur_desc_ptr | output | ADDR_W | Current descriptor address |
| cur_buf_ptr | output | ADDR_W | Next buffer byte address |

## Verification
Several properties are checked on every cycle: the stream holds while stalled, the buffer pointer steps by one per accepted byte, the bus requests hold steady until answered, the interrupt lasts a single cycle, and nothing moves once the end of the chain is reached. Other behaviour shows up only in the bench scenarios, each compared against a model that walks the chain in bench memory. These scenarios cover the byte order across unaligned lanes, chain following, empty and inverted buffers, write-back contents and their order against the stream, and the interrupt count. They also cover commands dropped while busy and a restart that re-services a finished final descriptor.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int DESC_WORDS = 4;
    localparam int WIDX_W   = $clog2(DESC_WORDS);

    // flag bit positions inside descriptor word 3
    localparam int FLAG_EOL  = 0;
    localparam int FLAG_INTR = 1;
    localparam int FLAG_DONE = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_CHECK  = 3'd2,
        ST_RDBYTE = 3'd3,
        ST_SEND   = 3'd4,
        ST_WB     = 3'd5
    } chan_st_e;

endpackage

// File: rtl/dchain_lane_sel.sv
module dchain_lane_sel
    import dchain_pkg::*;
(
    input  logic [WORD_W-1:0]        word_i,
    input  logic [$clog2(LANES)-1:0] lane_i,
    output logic [BYTE_W-1:0]        byte_o
);
    logic [BYTE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lanes[lane_i];
endmodule

// File: rtl/dchain_wb_word.sv
module dchain_wb_word
    import dchain_pkg::*;
(
    input  logic              eol_i,
    input  logic              intr_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o            = '0;
        word_o[FLAG_EOL]  = eol_i;
        word_o[FLAG_INTR] = intr_i;
        word_o[FLAG_DONE] = 1'b1;
    end
endmodule

// File: rtl/dchain_out_chan.sv
module dchain_out_chan
    import dchain_pkg::*;
#(
    parameter int ADDR_W = 32   // 4..32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_load,
    input  logic [ADDR_W-1:0] load_desc_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              buf_irq,
    output logic              end_of_list,
    output logic [ADDR_W-1:0] cur_desc_ptr,
    output logic [ADDR_W-1:0] cur_buf_ptr
);
    localparam int LANE_W = $clog2(LANES);
    localparam logic [ADDR_W-1:0] FLAGS_OFS = ADDR_W'(4 * (DESC_WORDS - 1));
    localparam logic [WIDX_W-1:0] LAST_WIDX = WIDX_W'(DESC_WORDS - 1);

    typedef struct packed {
        chan_st_e          st;
        logic [ADDR_W-1:0] desc;
        logic [ADDR_W-1:0] bufp;
        logic [ADDR_W-1:0] after;
        logic [ADDR_W-1:0] nxt;
        logic              f_eol;
        logic              f_intr;
        logic [WIDX_W-1:0] widx;
        logic              go;
        logic              reload;
        logic [BYTE_W-1:0] dat;
        logic              irq;
        logic              eol;
    } ctx_t;

    ctx_t r_q, r_d;

    logic [BYTE_W-1:0] lane_byte;
    logic [WORD_W-1:0] wb_word;

    dchain_lane_sel u_lane (
        .word_i (rd_data),
        .lane_i (r_q.bufp[LANE_W-1:0]),
        .byte_o (lane_byte)
    );

    dchain_wb_word u_wb (
        .eol_i  (r_q.f_eol),
        .intr_i (r_q.f_intr),
        .word_o (wb_word)
    );

    // next-state computation
    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    r_d.eol    = 1'b0;
                    r_d.go     = 1'b1;
                    r_d.reload = 1'b0;
                    r_d.widx   = '0;
                    r_d.st     = ST_FETCH;
                end else if (cmd_load) begin
                    r_d.desc   = load_desc_addr;
                    r_d.go     = 1'b0;
                    r_d.reload = 1'b1;
                    r_d.widx   = '0;
                    r_d.st     = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (rd_valid) begin
                    unique case (r_q.widx)
                        2'd0: if (r_q.reload) r_d.bufp = rd_data[ADDR_W-1:0];
                        2'd1: r_d.after = rd_data[ADDR_W-1:0];
                        2'd2: r_d.nxt   = rd_data[ADDR_W-1:0];
                        default: begin
                            r_d.f_eol  = rd_data[FLAG_EOL];
                            r_d.f_intr = rd_data[FLAG_INTR];
                        end
                    endcase
                    r_d.widx = r_q.widx + 1'b1;
                    if (r_q.widx == LAST_WIDX)
                        r_d.st = r_q.go ? ST_CHECK : ST_IDLE;
                end
            end
            ST_CHECK: begin
                if (r_q.bufp < r_q.after) begin
                    r_d.st = ST_RDBYTE;
                end else begin
                    r_d.irq = r_q.f_intr;
                    r_d.st  = ST_WB;
                end
            end
            ST_RDBYTE: begin
                if (rd_valid) begin
                    r_d.dat = lane_byte;
                    r_d.st  = ST_SEND;
                end
            end
            ST_SEND: begin
                if (out_ready) begin
                    r_d.bufp = r_q.bufp + 1'b1;
                    r_d.st   = ST_CHECK;
                end
            end
            ST_WB: begin
                if (wr_ack) begin
                    if (r_q.f_eol) begin
                        r_d.eol = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.desc   = r_q.nxt;
                        r_d.reload = 1'b1;
                        r_d.widx   = '0;
                        r_d.st     = ST_FETCH;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q     <= '0;
            r_q.eol <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // port drive
    always_comb begin
        rd_req  = (r_q.st == ST_FETCH) || (r_q.st == ST_RDBYTE);
        rd_addr = (r_q.st == ST_FETCH)
                ? r_q.desc + {{(ADDR_W-WIDX_W-2){1'b0}}, r_q.widx, 2'b00}
                : {r_q.bufp[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    end

    assign wr_req       = (r_q.st == ST_WB);
    assign wr_addr      = r_q.desc + FLAGS_OFS;
    assign wr_data      = wb_word;
    assign out_valid    = (r_q.st == ST_SEND);
    assign out_data     = r_q.dat;
    assign buf_irq      = r_q.irq;
    assign end_of_list  = r_q.eol;
    assign cur_desc_ptr = r_q.desc;
    assign cur_buf_ptr  = r_q.bufp;

    // checks next to the logic
    a_r4_stream_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(cur_buf_ptr));

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> cur_buf_ptr == $past(cur_buf_ptr) + 1'b1);

    a_r8_quiet_at_end: assert property (@(posedge clk) disable iff (rst)
        end_of_list |-> !out_valid && !wr_req && !buf_irq);

    a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
        buf_irq |=> !buf_irq);

    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    a_r11_wr_hold: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

    a_r11_one_port: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

endmodule

// File: tb/sim_dchain_out_chan.sv
module sim_dchain_out_chan;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int MEM_SZ = 1024;
    localparam int WDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0, cmd_load = 1'b0;
    logic [AW-1:0] load_desc_addr = '0;
    logic          rd_req, rd_valid = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data = '0;
    logic          wr_req, wr_ack = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          out_valid, out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          buf_irq, end_of_list;
    logic [AW-1:0] cur_desc_ptr, cur_buf_ptr;

    dchain_out_chan #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_load(cmd_load),
        .load_desc_addr(load_desc_addr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .buf_irq(buf_irq), .end_of_list(end_of_list),
        .cur_desc_ptr(cur_desc_ptr), .cur_buf_ptr(cur_buf_ptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // bench memory and chain model
    logic [7:0] mem [MEM_SZ];

    function automatic logic [31:0] word_at(input int a);
        int b;
        b = a & (MEM_SZ - 4);
        return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
    endfunction

    task automatic put_word(input int a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) mem[a+i] = w[8*i +: 8];
    endtask

    task automatic set_desc(input int d, input int bs, input int af, input int nx, input bit eol, input bit intr);
        put_word(d, bs); put_word(d+4, af); put_word(d+8, nx);
        put_word(d+12, {30'b0, intr, eol});
    endtask

    byte unsigned exp_data[$];
    int exp_addr[$], wb_addr[$], wb_data[$], wb_sent[$];
    int md_desc = 0, md_buf = 0;
    int planned = 0, sent = 0, irq_exp = 0, irq_seen = 0;

    task automatic plan_run();
        int d, b, af, fl;
        d = md_desc; b = md_buf;
        for (int k = 0; k < 20; k++) begin
            if (k != 0) b = word_at(d);
            af = word_at(d+4);
            fl = word_at(d+12);
            while (b < af) begin
                exp_data.push_back(mem[b]); exp_addr.push_back(b); b++; planned++;
            end
            wb_addr.push_back(d+12); wb_data.push_back((fl & 3) | 4); wb_sent.push_back(planned);
            if (fl & 2) irq_exp++;
            if (fl & 1) begin md_desc = d; md_buf = b; break; end
            d = word_at(d+8);
        end
    endtask

    // responders, client and per-cycle comparison, all at the negative edge
    int rd_lat = 0, wr_lat = 0, rdy_mode = 0;
    bit rd_wait = 0, wr_wait = 0, hold_prev = 0, busy_move = 0;
    int rd_left = 0, wr_left = 0;
    logic [AW-1:0] rd_hold_addr, wr_hold_addr;
    logic [7:0] hold_data;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            rd_valid = 0; wr_ack = 0; rd_wait = 0; wr_wait = 0; hold_prev = 0;
        end else begin
            // read port
            if (!rd_req) begin
                rd_valid = 0; rd_wait = 0;
            end else begin
                if (!rd_wait) begin
                    rd_wait = 1; rd_left = rd_lat; rd_hold_addr = rd_addr;
                end else
                    chk(rd_addr == rd_hold_addr, "R11 read address held", rd_addr, rd_hold_addr);
                if (rd_left == 0) begin
                    rd_valid = 1; rd_data = word_at(int'(rd_addr)); rd_wait = 0;
                end else begin
                    rd_valid = 0; rd_left--;
                end
            end
            chk(!(rd_req && wr_req), "R11 single port", {rd_req, wr_req}, 0);
            // write port
            if (!wr_req) begin
                wr_ack = 0; wr_wait = 0;
            end else begin
                if (!wr_wait) begin
                    wr_wait = 1; wr_left = wr_lat; wr_hold_addr = wr_addr;
                end else
                    chk(wr_addr == wr_hold_addr, "R11 write address held", wr_addr, wr_hold_addr);
                if (wr_left == 0) begin
                    wr_ack = 1; wr_wait = 0;
                    if (wb_addr.size() == 0)
                        chk(0, "R7 unexpected write-back", wr_addr, 0);
                    else begin
                        chk(wr_addr == wb_addr[0], "R7 write-back address", wr_addr, wb_addr[0]);
                        chk(wr_data == wb_data[0], "R7 write-back word", wr_data, wb_data[0]);
                        chk(sent == wb_sent[0], "R7 buffer done before write-back", sent, wb_sent[0]);
                        void'(wb_addr.pop_front()); void'(wb_data.pop_front()); void'(wb_sent.pop_front());
                    end
                    put_word(int'(wr_addr), wr_data);
                end else begin
                    wr_ack = 0; wr_left--;
                end
            end
            // client
            case (rdy_mode)
                0: out_ready = 1;
                1: out_ready = (cyc % 3) != 0;
                default: out_ready = cyc[0];
            endcase
            if (hold_prev) begin
                chk(out_valid, "R4 valid held", out_valid, 1);
                chk(out_data == hold_data, "R4 data held", out_data, hold_data);
            end
            hold_prev = out_valid && !out_ready;
            hold_data = out_data;
            if (out_valid) busy_move = 1;
            if (out_valid && out_ready) begin
                if (exp_data.size() == 0)
                    chk(0, "R5 unexpected byte", out_data, 0);
                else begin
                    chk(out_data == exp_data[0], "R3 byte value", out_data, exp_data[0]);
                    chk(cur_buf_ptr == exp_addr[0], "R4 buffer pointer", cur_buf_ptr, exp_addr[0]);
                    void'(exp_data.pop_front()); void'(exp_addr.pop_front());
                end
                sent++;
            end
            if (buf_irq) irq_seen++;
        end
    end

    task automatic pulse(input bit st, input bit ld, input int a);
        @(negedge clk);
        cmd_start = st; cmd_load = ld; load_desc_addr = a;
        @(negedge clk);
        cmd_start = 0; cmd_load = 0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (end_of_list && !rd_req && !wr_req) break;
        end
    endtask

    task automatic finish_run(input string tag, input int dptr, input int bptr);
        chk(end_of_list, {tag, " R8 stopped at end"}, end_of_list, 1);
        chk(exp_data.size() == 0, {tag, " R3 all bytes sent"}, exp_data.size(), 0);
        chk(wb_addr.size() == 0, {tag, " R7 all write-backs"}, wb_addr.size(), 0);
        chk(irq_seen == irq_exp, {tag, " R6 interrupt count"}, irq_seen, irq_exp);
        chk(cur_desc_ptr == dptr, {tag, " R9 final descriptor"}, cur_desc_ptr, dptr);
        chk(cur_buf_ptr == bptr, {tag, " R9 final buffer pointer"}, cur_buf_ptr, bptr);
        busy_move = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!rd_req && !wr_req && !out_valid, {tag, " R8 quiet after end"}, {rd_req, wr_req, out_valid}, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'(i * 7 + 3);
        // chain A: unaligned, empty, inverted, final
        set_desc(32'h100, 32'h200, 32'h205, 32'h110, 0, 1);
        set_desc(32'h110, 32'h223, 32'h223, 32'h120, 0, 1);
        set_desc(32'h120, 32'h231, 32'h22f, 32'h130, 0, 0);
        set_desc(32'h130, 32'h241, 32'h24a, 32'h000, 1, 1);
        // chain B
        set_desc(32'h180, 32'h2f0, 32'h2fc, 32'h190, 0, 0);
        set_desc(32'h190, 32'h301, 32'h308, 32'h000, 1, 0);

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(end_of_list, "R1 eol after reset", end_of_list, 1);
        chk(cur_desc_ptr == 0 && cur_buf_ptr == 0, "R1 pointers cleared", cur_buf_ptr, 0);
        chk(!rd_req && !wr_req && !out_valid && !buf_irq, "R1 outputs idle",
            {rd_req, wr_req, out_valid, buf_irq}, 0);

        // R2 context load, no start
        busy_move = 0;
        pulse(0, 1, 32'h100);
        md_desc = 32'h100; md_buf = word_at(32'h100);
        repeat (30) @(negedge clk);
        chk(cur_desc_ptr == 32'h100, "R2 descriptor loaded", cur_desc_ptr, 32'h100);
        chk(cur_buf_ptr == 32'h200, "R2 buffer loaded", cur_buf_ptr, 32'h200);
        chk(end_of_list, "R2 eol unchanged", end_of_list, 1);
        chk(!busy_move && !rd_req, "R2 channel not started", busy_move, 0);

        // chain A run with busy-time commands
        plan_run();
        pulse(1, 0, 0);
        chk(!end_of_list, "R3 start clears eol", end_of_list, 0);
        repeat (6) @(negedge clk);
        pulse(1, 1, 32'h300);   // R10: must be ignored
        wait_end();
        finish_run("A", 32'h130, 32'h24a);

        // restart without load: final descriptor has nothing left (R5)
        rd_lat = 2; wr_lat = 1; rdy_mode = 1;
        irq_seen = 0; irq_exp = 0;
        plan_run();
        pulse(1, 0, 0);
        chk(!end_of_list, "R3 restart clears eol", end_of_list, 0);
        wait_end();
        chk(sent == planned, "R5 no bytes on restart", sent, planned);
        finish_run("restart", 32'h130, 32'h24a);

        // chain B with stalls on every side; start wins over load (R10)
        rd_lat = 1; wr_lat = 2; rdy_mode = 2;
        irq_seen = 0; irq_exp = 0;
        pulse(0, 1, 32'h180);
        md_desc = 32'h180; md_buf = word_at(32'h180);
        repeat (40) @(negedge clk);
        chk(cur_buf_ptr == 32'h2f0, "R2 second load buffer", cur_buf_ptr, 32'h2f0);
        plan_run();
        pulse(1, 1, 32'h100);
        wait_end();
        finish_run("B", 32'h190, 32'h308);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WDOG);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule